// File: doc/BRIEF.md
# Grouped Event Combiner with Masking

This block collects single-cycle event pulses from up to 128 sources and keeps each one as a sticky flag until software clears it. The sources are split into four groups of 32. Event number n is held in group n/32 at bit n%32. Software reaches the block through a word-addressed read/write port. Through this port it can read the raw flags, set or clear flags by writing ones, and program two independent per-group masks. One mask controls the combined interrupts and the other controls the exception path.

Each group reduces its unmasked flags to one registered, level-sensitive combined interrupt. The four combined interrupts are routed back in as event numbers 0 to 3, so a later stage of combining can see which groups are active. A second view of the same flags, gated by the exception mask, drives one registered exception output. A write-only assert register lets software raise any event by its number.

Top module: `evc_combiner`

## Requirements
- R1: After a synchronous reset, every flag is 0, both masks of every group read all ones (everything blocked), and the combined and exception outputs are low.
- R2: A one-cycle pulse on event input n, for n from 4 to 127, sets flag bit n%32 of group n/32. The flag can be read one cycle later and stays set until it is cleared.
- R3: Writing the set register of a group sets every flag bit written as 1. Bits written as 0 keep their value.
- R4: Writing the clear register of a group clears every flag bit written as 1. Bits written as 0 keep their value.
- R5: When a hardware event and a software clear reach the same flag in the same cycle, the flag stays set.
- R6: The masked-flag view of a group reads as flag AND NOT interrupt-mask. A mask bit of 1 blocks the event and a mask bit of 0 passes it.
- R7: Combined output g goes high one clock after any unmasked flag of group g is high. It goes low one clock after none is high.
- R8: The masked exception view reads as flag AND NOT exception-mask, independently of the interrupt mask. The exception output goes high or low one clock after the OR of all groups' masked exception flags changes.
- R9: Combined output g feeds flag bit g of group 0 (event numbers 0 to 3). The event input pins 0 to 3 are ignored.
- R10: Writing the assert register with an event number in data bits [6:0] sets that event's flag in the next cycle.
- R11: The word address is {kind[3:0], group[1:0]}. The kinds are: 0 flag, 1 set, 2 clear, 3 reserved, 4 interrupt mask, 5 masked flag, 6 exception mask, 7 masked exception flag, 8 assert. Read data appears one cycle after rd_en. Reads of kinds 1, 2, 3 and 8 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 128 | Single-cycle event pulses, bit n is event n |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Word address {kind, group} |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| comb_irq_o | output | 4 | Registered combined interrupt per group |
| exc_o | output | 1 | Registered exception output |

## Verification
A flag that is lost, stuck or in the wrong bit position shows up in the raw flag read one cycle after the event. The sweep over all 128 event numbers and all 128 assert codes finds it there. A mask that has the wrong polarity, or that is shared between the two paths, shows up within two clocks as a combined or exception output that turns on or fails to drop. It also shows up in the two masked views. A broken feedback path leaves group 0 bits 0 to 3 clear while a combined output is high, or sets them from the ignored pins.

// File: rtl/evc_pkg.sv
package evc_pkg;
  typedef enum logic [3:0] {
    K_FLAG   = 4'd0,
    K_SET    = 4'd1,
    K_CLR    = 4'd2,
    K_RSV    = 4'd3,
    K_MASK   = 4'd4,
    K_MFLAG  = 4'd5,
    K_XMASK  = 4'd6,
    K_XFLAG  = 4'd7,
    K_ASSERT = 4'd8
  } reg_kind_e;
endpackage

// File: rtl/evc_decode.sv
module evc_decode #(
  parameter int NUM_GROUPS = 4,
  parameter int GROUP_W    = 32,
  parameter int GRP_AW     = 2,
  parameter int EVT_AW     = 7
) (
  input  logic                          wr_en,
  input  logic [3:0]                    kind,
  input  logic [GRP_AW-1:0]             grp,
  input  logic [GROUP_W-1:0]            wdata,
  output logic [NUM_GROUPS*GROUP_W-1:0] set_bits,
  output logic [NUM_GROUPS*GROUP_W-1:0] clr_bits,
  output logic [NUM_GROUPS-1:0]         mask_we,
  output logic [NUM_GROUPS-1:0]         xmask_we
);
  import evc_pkg::*;
  localparam int NUM_EVT = NUM_GROUPS * GROUP_W;

  logic              grp_ok;
  logic [EVT_AW-1:0] evt_num;
  logic [NUM_EVT-1:0] asrt_hot;

  assign grp_ok  = {1'b0, grp} < (GRP_AW+1)'(NUM_GROUPS);
  assign evt_num = wdata[EVT_AW-1:0];

  always_comb begin
    asrt_hot = '0;
    if (wr_en && kind == K_ASSERT && ({1'b0, evt_num} < (EVT_AW+1)'(NUM_EVT)))
      asrt_hot = NUM_EVT'(1) << evt_num;
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_dec
    logic hit;
    assign hit = wr_en && grp_ok && (grp == GRP_AW'(g));
    assign set_bits[g*GROUP_W +: GROUP_W] =
      ((hit && kind == K_SET) ? wdata : '0) | asrt_hot[g*GROUP_W +: GROUP_W];
    assign clr_bits[g*GROUP_W +: GROUP_W] = (hit && kind == K_CLR) ? wdata : '0;
    assign mask_we[g]  = hit && kind == K_MASK;
    assign xmask_we[g] = hit && kind == K_XMASK;
  end
endmodule

// File: rtl/evc_group.sv
module evc_group #(
  parameter int GROUP_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [GROUP_W-1:0] evt_i,
  input  logic [GROUP_W-1:0] set_i,
  input  logic [GROUP_W-1:0] clr_i,
  input  logic               mask_we,
  input  logic               xmask_we,
  input  logic [GROUP_W-1:0] wdata,
  output logic [GROUP_W-1:0] flag_o,
  output logic [GROUP_W-1:0] mask_o,
  output logic [GROUP_W-1:0] xmask_o,
  output logic               irq_o,
  output logic               xpend_o
);
  logic [GROUP_W-1:0] flag_q, mask_q, xmask_q;
  logic               irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= '0;
      mask_q  <= '1;
      xmask_q <= '1;
      irq_q   <= 1'b0;
    end else begin
      flag_q <= (flag_q & ~clr_i) | evt_i | set_i;
      if (mask_we)  mask_q  <= wdata;
      if (xmask_we) xmask_q <= wdata;
      irq_q <= |(flag_q & ~mask_q);
    end
  end

  assign flag_o  = flag_q;
  assign mask_o  = mask_q;
  assign xmask_o = xmask_q;
  assign irq_o   = irq_q;
  assign xpend_o = |(flag_q & ~xmask_q);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (flag_q == '0 && mask_q == '1 && xmask_q == '1 && !irq_q));
  // R5
  event_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flag_q & $past(evt_i)) == $past(evt_i)));
  // R4
  clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flag_q & $past(clr_i & ~evt_i & ~set_i)) == '0));
  // R7
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (|(flag_q & ~mask_q)) |=> irq_o);
  // R7
  irq_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !(|(flag_q & ~mask_q)) |=> !irq_o);
endmodule

// File: rtl/evc_combiner.sv
module evc_combiner #(
  parameter int NUM_GROUPS = 4,
  parameter int GROUP_W    = 32,
  localparam int NUM_EVT   = NUM_GROUPS * GROUP_W,
  localparam int GRP_AW    = $clog2(NUM_GROUPS),
  localparam int EVT_AW    = $clog2(NUM_EVT),
  localparam int ADDR_W    = 4 + GRP_AW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [GROUP_W-1:0] wdata,
  output logic [GROUP_W-1:0] rdata,
  output logic [NUM_GROUPS-1:0] comb_irq_o,
  output logic               exc_o
);
  import evc_pkg::*;

  localparam logic [NUM_EVT-1:0] FB_MASK =
    {{(NUM_EVT-NUM_GROUPS){1'b0}}, {NUM_GROUPS{1'b1}}};

  logic [3:0]          kind;
  logic [GRP_AW-1:0]   grp;
  logic [NUM_EVT-1:0]  set_bits, clr_bits, evt_eff;
  logic [NUM_EVT-1:0]  flag_all, mask_all, xmask_all;
  logic [NUM_GROUPS-1:0] mask_we, xmask_we, irq_v, xpend_v;
  logic                exc_q;
  logic [GROUP_W-1:0]  rdata_q;

  assign kind = addr[ADDR_W-1 -: 4];
  assign grp  = addr[GRP_AW-1:0];

  // combined outputs re-enter as the lowest event numbers
  assign evt_eff = (evt_i & ~FB_MASK) | NUM_EVT'(irq_v);

  evc_decode #(
    .NUM_GROUPS(NUM_GROUPS), .GROUP_W(GROUP_W), .GRP_AW(GRP_AW), .EVT_AW(EVT_AW)
  ) u_dec (
    .wr_en(wr_en), .kind(kind), .grp(grp), .wdata(wdata),
    .set_bits(set_bits), .clr_bits(clr_bits),
    .mask_we(mask_we), .xmask_we(xmask_we)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    evc_group #(.GROUP_W(GROUP_W)) u_grp (
      .clk(clk), .rst(rst),
      .evt_i(evt_eff[g*GROUP_W +: GROUP_W]),
      .set_i(set_bits[g*GROUP_W +: GROUP_W]),
      .clr_i(clr_bits[g*GROUP_W +: GROUP_W]),
      .mask_we(mask_we[g]), .xmask_we(xmask_we[g]), .wdata(wdata),
      .flag_o(flag_all[g*GROUP_W +: GROUP_W]),
      .mask_o(mask_all[g*GROUP_W +: GROUP_W]),
      .xmask_o(xmask_all[g*GROUP_W +: GROUP_W]),
      .irq_o(irq_v[g]), .xpend_o(xpend_v[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      exc_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      exc_q <= |xpend_v;
      if (rd_en) begin
        if ({1'b0, grp} < (GRP_AW+1)'(NUM_GROUPS)) begin
          case (kind)
            K_FLAG:  rdata_q <= flag_all[grp*GROUP_W +: GROUP_W];
            K_MASK:  rdata_q <= mask_all[grp*GROUP_W +: GROUP_W];
            K_MFLAG: rdata_q <= flag_all[grp*GROUP_W +: GROUP_W]
                              & ~mask_all[grp*GROUP_W +: GROUP_W];
            K_XMASK: rdata_q <= xmask_all[grp*GROUP_W +: GROUP_W];
            K_XFLAG: rdata_q <= flag_all[grp*GROUP_W +: GROUP_W]
                              & ~xmask_all[grp*GROUP_W +: GROUP_W];
            default: rdata_q <= '0;
          endcase
        end else begin
          rdata_q <= '0;
        end
      end
    end
  end

  assign rdata      = rdata_q;
  assign comb_irq_o = irq_v;
  assign exc_o      = exc_q;

  // R8
  exc_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (|xpend_v) |=> exc_o);
  // R8
  exc_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !(|xpend_v) |=> !exc_o);
  // R9
  feedback_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flag_all[NUM_GROUPS-1:0] & $past(irq_v)) == $past(irq_v)));
  // R10
  assert_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && kind == K_ASSERT) |=> flag_all[$past(wdata[EVT_AW-1:0])]);
  // R11
  wo_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (kind == K_SET || kind == K_CLR || kind == K_RSV || kind == K_ASSERT))
      |=> (rdata == '0));
endmodule

// File: tb/evc_combiner_test.sv
`timescale 1ns/1ps
module evc_combiner_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [127:0] evt_i = '0;
  logic         wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [3:0]   comb_irq_o;
  logic         exc_o;
  int checks = 0, fails = 0;
  bit done = 0;

  evc_combiner uut (
    .clk(clk), .rst(rst), .evt_i(evt_i), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .comb_irq_o(comb_irq_o), .exc_o(exc_o)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int kind, input int g, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = {4'(kind), 2'(g)}; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int kind, input int g, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = {4'(kind), 2'(g)};
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic pulse(input int n);
    @(negedge clk);
    evt_i = '0; evt_i[n] = 1'b1;
    @(negedge clk);
    evt_i = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, acc;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 comb", 32'(comb_irq_o), 0);
    chk("R1 exc", 32'(exc_o), 0);
    for (int g = 0; g < 4; g++) begin
      rd(4, g, v); chk("R1 mask", v, 32'hFFFF_FFFF);
      rd(6, g, v); chk("R1 xmask", v, 32'hFFFF_FFFF);
      rd(0, g, v); chk("R1 flag", v, 0);
    end
    // R9 pins 0..3 ignored
    for (int n = 0; n < 4; n++) pulse(n);
    rd(0, 0, v); chk("R9 pins ignored", v, 0);
    // R2/R4/R6 sweep over hardware events
    for (int n = 4; n < 128; n++) begin
      pulse(n);
      @(negedge clk);
      chk("R6 masked comb", 32'(comb_irq_o), 0);
      rd(0, n / 32, v); chk("R2 flag", v, 32'(1) << (n % 32));
      rd(5, n / 32, v); chk("R6 mflag blocked", v, 0);
      wr(2, n / 32, 32'(1) << (n % 32));
      rd(0, n / 32, v); chk("R4 cleared", v, 0);
    end
    // R3 set, zeros unchanged
    wr(1, 2, 32'hA5A5_0F0F);
    rd(0, 2, v); chk("R3 set", v, 32'hA5A5_0F0F);
    wr(1, 2, 32'h0000_0010);
    rd(0, 2, v); chk("R3 set keep", v, 32'hA5A5_0F1F);
    // R4 partial clear
    wr(2, 2, 32'h0000_0F00);
    rd(0, 2, v); chk("R4 partial", v, 32'hA5A5_001F);
    wr(2, 2, 32'hFFFF_FFFF);
    rd(0, 2, v); chk("R4 all", v, 0);
    // R5 event beats clear
    wr(1, 2, 32'h80);
    @(negedge clk);
    evt_i = '0; evt_i[70] = 1'b1;
    wr_en = 1'b1; addr = {4'd2, 2'd2}; wdata = 32'hC0;
    @(negedge clk);
    evt_i = '0; wr_en = 1'b0;
    rd(0, 2, v); chk("R5 event wins", v, 32'h40);
    // R6/R7 unmask, combined output rises
    wr(4, 2, ~32'h40);
    @(negedge clk);
    chk("R7 comb rise", 32'(comb_irq_o), 32'h4);
    rd(5, 2, v); chk("R6 mflag", v, 32'h40);
    // R9 feedback into group 0 bit 2
    rd(0, 0, v); chk("R9 feedback", v, 32'h4);
    wr(2, 2, 32'h40);
    @(negedge clk);
    chk("R7 comb fall", 32'(comb_irq_o), 0);
    wr(2, 0, 32'h4);
    wr(4, 2, 32'hFFFF_FFFF);
    rd(0, 0, v); chk("R9 cleared", v, 0);
    // R8 exception path
    wr(6, 1, ~(32'(1) << 9));
    pulse(41);
    @(negedge clk);
    chk("R8 exc rise", 32'(exc_o), 1);
    chk("R8 comb independent", 32'(comb_irq_o), 0);
    rd(7, 1, v); chk("R8 xflag", v, 32'(1) << 9);
    wr(2, 1, 32'(1) << 9);
    @(negedge clk);
    chk("R8 exc fall", 32'(exc_o), 0);
    wr(6, 1, 32'hFFFF_FFFF);
    // R10 assert register sweep
    for (int n = 0; n < 128; n++) begin
      wr(8, 0, 32'(n) | 32'hFFFF_FF00);
      rd(0, n / 32, v); chk("R10 assert", v, 32'(1) << (n % 32));
      wr(2, n / 32, 32'hFFFF_FFFF);
    end
    // R11 write-only and reserved kinds read as 0
    wr(1, 3, 32'h0000_FFFF);
    acc = 0;
    rd(1, 3, v); acc |= v;
    rd(2, 3, v); acc |= v;
    rd(3, 3, v); acc |= v;
    rd(8, 3, v); acc |= v;
    chk("R11 wo reads zero", acc, 0);
    rd(0, 3, v); chk("R11 flag map", v, 32'h0000_FFFF);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule